// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in a two-wide in-order front end, ahead of register-file read. Each cycle it looks at two decoded instructions, the older in slot 0 and the younger in slot 1, and decides whether both can issue together into an asymmetric pair of pipes. The primary pipe is full-featured. The secondary pipe handles only the common class of instruction. The decision and the routed instruction fields are registered, so they appear at the outputs one clock after the slots are presented.

The older instruction always goes to the primary pipe. The younger one joins it on the secondary pipe only when four conditions hold. Its class must allow either pipe. The older instruction must not claim both pipes. Neither of its sources may read the older instruction's destination. Both instructions must not write the same destination. When pairing is refused, only the older instruction issues and a hold flag tells the front end to move the younger instruction into slot 0 on the next cycle.

The control is a four-state machine whose state is the decision now being presented to the pipes:
- `ST_IDLE`: nothing issues.
- `ST_SOLO`: slot 0 issues alone because slot 1 was empty.
- `ST_SPLIT`: slot 0 issues alone and slot 1 is held.
- `ST_DUAL`: both slots issue.

Every state can move to every other state each cycle, and the next state depends only on the inputs:
- slot 0 invalid goes to `ST_IDLE`;
- slot 0 valid with slot 1 invalid goes to `ST_SOLO`;
- both valid and pairable goes to `ST_DUAL`;
- both valid but not pairable goes to `ST_SPLIT`.

Top module: `pair_issue_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is 0.
- R2: If slot 0 is invalid at a clock edge, then after that edge `pri_issue`, `sec_issue` and `hold_young` are all 0, whatever slot 1 holds.
- R3: If slot 0 is valid and slot 1 is invalid, then after the edge `pri_issue`=1, `sec_issue`=0 and `hold_young`=0.
- R4: Both instructions pair when all of the following hold:
  - both slots are valid;
  - slot 1 has class 2'b00 (either pipe);
  - slot 0 has class 2'b00 or 2'b01;
  - there is no register conflict.

  When they pair, both issue one cycle later. The primary pipe carries slot 0's fields and the secondary pipe carries slot 1's fields.
- R5: If any source of slot 1 equals a nonzero slot 0 destination, the pair is refused. Source k occupies bits [k*REG_W +: REG_W] of the source vector.
- R6: If both slots name the same nonzero destination, the pair is refused.
- R7: Register index 0 never creates a conflict. When slot 0's destination is 0, matching sources or destinations do not refuse the pair.
- R8: A slot 1 class of 2'b01 (primary pipe only) refuses the pair.
- R9: A class of 2'b10 (both pipes) or 2'b11 (reserved, treated the same) in either slot refuses the pair.
- R10: Each decision appears exactly one cycle after its inputs. The destination and source outputs of a pipe that does not issue are 0.
- R11: `hold_young` is 1 exactly when slot 0 issued, slot 1 was valid, and the two did not pair. When it is 1, `sec_issue` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_class | input | 2 | Slot 0 pipe class: 00 either, 01 primary only, 10 both, 11 reserved (treated as both) |
| s0_dst | input | REG_W (5) | Slot 0 destination index, 0 means none |
| s0_src | input | NUM_SRC*REG_W (10) | Slot 0 sources, source k at bits [k*REG_W +: REG_W] |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_class | input | 2 | Slot 1 pipe class, same encoding as slot 0 |
| s1_dst | input | REG_W (5) | Slot 1 destination index |
| s1_src | input | NUM_SRC*REG_W (10) | Slot 1 sources |
| pri_issue | output | 1 | Primary pipe receives an instruction this cycle |
| sec_issue | output | 1 | Secondary pipe receives an instruction this cycle |
| hold_young | output | 1 | Slot 1 was not issued and must move to slot 0 next |
| pri_dst | output | REG_W (5) | Destination routed to the primary pipe |
| pri_src | output | NUM_SRC*REG_W (10) | Sources routed to the primary pipe |
| sec_dst | output | REG_W (5) | Destination routed to the secondary pipe |
| sec_src | output | NUM_SRC*REG_W (10) | Sources routed to the secondary pipe |

## Verification
A wrong next-state choice shows up at the ports one cycle after the offending slot pair. It appears as a wrong combination of `pri_issue`, `sec_issue` and `hold_young`, or as a stale or nonzero field on a pipe that should be idle. Because the state carries only the last decision and nothing older, an error never lingers beyond the following cycle. The reference model therefore compares every output on every clock against the slots presented one edge earlier. The stimulus uses a small register range so that read-after-write and write-after-write hits, register 0, and every class combination occur often.

// File: rtl/pair_pkg.sv
package pair_pkg;

    // Pipe class of a decoded instruction
    typedef enum logic [1:0] {
        CLS_EITHER  = 2'b00,
        CLS_PRIMARY = 2'b01,
        CLS_BOTH    = 2'b10,
        CLS_RSVD    = 2'b11
    } pipe_cls_e;

    // Issue decision presented to the pipes this cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SOLO  = 2'b01,
        ST_SPLIT = 2'b10,
        ST_DUAL  = 2'b11
    } issue_st_e;

endpackage

// File: rtl/pair_dep_check.sv
module pair_dep_check #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_W-1:0]         older_dst,
    input  logic [REG_W-1:0]         young_dst,
    input  logic [NUM_SRC*REG_W-1:0] young_src,
    output logic                     raw_hit,
    output logic                     waw_hit
);
    localparam int SRC_W = NUM_SRC * REG_W;

    logic             older_writes;
    logic [NUM_SRC-1:0] src_match;

    // Register 0 is never a real producer
    assign older_writes = (older_dst != '0);

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
            assign src_match[k] = (young_src[k*REG_W +: REG_W] == older_dst);
        end
    endgenerate

    assign raw_hit = older_writes && (|src_match);
    assign waw_hit = older_writes && (young_dst == older_dst);

    logic unused_w;
    assign unused_w = ^SRC_W;
endmodule

// File: rtl/pair_class_rules.sv
module pair_class_rules
    import pair_pkg::*;
(
    input  logic [1:0] older_cls,
    input  logic [1:0] young_cls,
    output logic       class_ok
);
    pipe_cls_e o_cls;
    pipe_cls_e y_cls;
    logic      older_excl;
    logic      young_sec_ok;

    assign o_cls = pipe_cls_e'(older_cls);
    assign y_cls = pipe_cls_e'(young_cls);

    // An instruction claiming both pipes (or the reserved code) blocks pairing
    always_comb begin
        unique case (o_cls)
            CLS_EITHER, CLS_PRIMARY: older_excl = 1'b0;
            CLS_BOTH, CLS_RSVD:      older_excl = 1'b1;
            default:                 older_excl = 1'b1;
        endcase
    end

    // The secondary pipe takes only the common class
    always_comb begin
        unique case (y_cls)
            CLS_EITHER: young_sec_ok = 1'b1;
            CLS_PRIMARY, CLS_BOTH, CLS_RSVD: young_sec_ok = 1'b0;
            default:    young_sec_ok = 1'b0;
        endcase
    end

    assign class_ok = !older_excl && young_sec_ok;
endmodule

// File: rtl/pair_issue_ctrl.sv
module pair_issue_ctrl
    import pair_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s0_valid,
    input  logic [1:0]               s0_class,
    input  logic [REG_W-1:0]         s0_dst,
    input  logic [NUM_SRC*REG_W-1:0] s0_src,
    input  logic                     s1_valid,
    input  logic [1:0]               s1_class,
    input  logic [REG_W-1:0]         s1_dst,
    input  logic [NUM_SRC*REG_W-1:0] s1_src,
    output logic                     pri_issue,
    output logic                     sec_issue,
    output logic                     hold_young,
    output logic [REG_W-1:0]         pri_dst,
    output logic [NUM_SRC*REG_W-1:0] pri_src,
    output logic [REG_W-1:0]         sec_dst,
    output logic [NUM_SRC*REG_W-1:0] sec_src
);
    localparam int SRC_W = NUM_SRC * REG_W;

    issue_st_e        state_q, state_d;
    logic             raw_hit, waw_hit, class_ok, can_pair;
    logic [REG_W-1:0] pdst_q, sdst_q;
    logic [SRC_W-1:0] psrc_q, ssrc_q;

    pair_dep_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_dep (
        .older_dst (s0_dst),
        .young_dst (s1_dst),
        .young_src (s1_src),
        .raw_hit   (raw_hit),
        .waw_hit   (waw_hit)
    );

    pair_class_rules u_cls (
        .older_cls (s0_class),
        .young_cls (s1_class),
        .class_ok  (class_ok)
    );

    assign can_pair = class_ok && !raw_hit && !waw_hit;

    // Next decision from the current slots
    always_comb begin
        if (!s0_valid)      state_d = ST_IDLE;
        else if (!s1_valid) state_d = ST_SOLO;
        else if (can_pair)  state_d = ST_DUAL;
        else                state_d = ST_SPLIT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Routed fields, zero for a pipe that does not receive an instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdst_q <= '0;
            psrc_q <= '0;
            sdst_q <= '0;
            ssrc_q <= '0;
        end else begin
            pdst_q <= (state_d != ST_IDLE) ? s0_dst : '0;
            psrc_q <= (state_d != ST_IDLE) ? s0_src : '0;
            sdst_q <= (state_d == ST_DUAL) ? s1_dst : '0;
            ssrc_q <= (state_d == ST_DUAL) ? s1_src : '0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        pri_issue  = 1'b0;
        sec_issue  = 1'b0;
        hold_young = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SOLO:  pri_issue = 1'b1;
            ST_SPLIT: begin
                pri_issue  = 1'b1;
                hold_young = 1'b1;
            end
            ST_DUAL: begin
                pri_issue = 1'b1;
                sec_issue = 1'b1;
            end
            default:  ;
        endcase
    end

    assign pri_dst = pdst_q;
    assign pri_src = psrc_q;
    assign sec_dst = sdst_q;
    assign sec_src = ssrc_q;
endmodule

// File: rtl/pair_issue_ctrl_chk.sv
module pair_issue_ctrl_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     s0_valid,
    input logic [1:0]               s0_class,
    input logic [REG_W-1:0]         s0_dst,
    input logic [NUM_SRC*REG_W-1:0] s0_src,
    input logic                     s1_valid,
    input logic [1:0]               s1_class,
    input logic [REG_W-1:0]         s1_dst,
    input logic [NUM_SRC*REG_W-1:0] s1_src,
    input logic                     pri_issue,
    input logic                     sec_issue,
    input logic                     hold_young,
    input logic [REG_W-1:0]         pri_dst,
    input logic [NUM_SRC*REG_W-1:0] pri_src,
    input logic [REG_W-1:0]         sec_dst,
    input logic [NUM_SRC*REG_W-1:0] sec_src
);
    p_sec_needs_pri_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_issue |-> pri_issue);

    p_hold_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_young |-> (pri_issue && !sec_issue));

    p_idle_on_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s0_valid |=> (!pri_issue && !sec_issue && !hold_young));

    p_solo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && !s1_valid) |=> (pri_issue && !sec_issue && !hold_young));

    p_waw_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && s0_dst != '0 && s0_dst == s1_dst)
        |=> (!sec_issue && hold_young));

    p_prim_only_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && s1_class == 2'b01) |=> (!sec_issue && hold_young));

    p_both_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && (s0_class[1] || s1_class[1])) |=> !sec_issue);

    p_pri_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s0_valid |=> (pri_dst == $past(s0_dst) && pri_src == $past(s0_src)));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_issue |-> (sec_dst == '0 && sec_src == '0));

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_raw
            p_raw_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (s0_valid && s1_valid && s0_dst != '0 &&
                 s1_src[k*REG_W +: REG_W] == s0_dst) |=> (!sec_issue && hold_young));
        end
    endgenerate
endmodule

bind pair_issue_ctrl pair_issue_ctrl_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_class(s0_class), .s0_dst(s0_dst), .s0_src(s0_src),
    .s1_valid(s1_valid), .s1_class(s1_class), .s1_dst(s1_dst), .s1_src(s1_src),
    .pri_issue(pri_issue), .sec_issue(sec_issue), .hold_young(hold_young),
    .pri_dst(pri_dst), .pri_src(pri_src), .sec_dst(sec_dst), .sec_src(sec_src)
);

// File: tb/pair_issue_ctrl_test.sv
`timescale 1ns/1ps
module pair_issue_ctrl_test;
    localparam int RW = 5;
    localparam int NS = 2;
    localparam int SW = RW * NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_valid, s1_valid;
    logic [1:0] s0_class, s1_class;
    logic [RW-1:0] s0_dst, s1_dst;
    logic [SW-1:0] s0_src, s1_src;
    logic pri_issue, sec_issue, hold_young;
    logic [RW-1:0] pri_dst, sec_dst;
    logic [SW-1:0] pri_src, sec_src;

    always #4 clk = ~clk;

    pair_issue_ctrl #(.REG_W(RW), .NUM_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_class(s0_class), .s0_dst(s0_dst), .s0_src(s0_src),
        .s1_valid(s1_valid), .s1_class(s1_class), .s1_dst(s1_dst), .s1_src(s1_src),
        .pri_issue(pri_issue), .sec_issue(sec_issue), .hold_young(hold_young),
        .pri_dst(pri_dst), .pri_src(pri_src), .sec_dst(sec_dst), .sec_src(sec_src)
    );

    typedef struct packed {
        logic          pri;
        logic          sec;
        logic          hold;
        logic [RW-1:0] pdst;
        logic [SW-1:0] psrc;
        logic [RW-1:0] sdst;
        logic [SW-1:0] ssrc;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: integer loops over the slots
    task automatic predict(output exp_t e, output string tag);
        int raw = 0, waw = 0, pair;
        int d0 = int'(s0_dst);
        for (int k = 0; k < NS; k++)
            if (d0 != 0 && int'(s1_src[k*RW +: RW]) == d0) raw = 1;
        if (d0 != 0 && int'(s1_dst) == d0) waw = 1;
        pair = (s0_valid && s1_valid && s0_class < 2 && s1_class == 0 && !raw && !waw) ? 1 : 0;
        e = '0;
        if (s0_valid) begin
            e.pri  = 1'b1;
            e.pdst = s0_dst;
            e.psrc = s0_src;
            if (pair != 0) begin
                e.sec  = 1'b1;
                e.sdst = s1_dst;
                e.ssrc = s1_src;
            end else if (s1_valid) begin
                e.hold = 1'b1;
            end
        end
        if (!s0_valid)                          tag = "R2";
        else if (!s1_valid)                     tag = "R3";
        else if (s0_class >= 2 || s1_class >= 2) tag = "R9";
        else if (s1_class == 1)                 tag = "R8";
        else if (raw != 0)                      tag = "R5";
        else if (waw != 0)                      tag = "R6";
        else if (d0 == 0)                       tag = "R7";
        else                                    tag = "R4";
    endtask

    task automatic compare_pending();
        exp_t e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'({pri_issue, sec_issue}), 64'({e.pri, e.sec}));
        check("R11", 64'(hold_young), 64'(e.hold));
        check("R10", 64'({pri_dst, pri_src, sec_dst, sec_src}),
                     64'({e.pdst, e.psrc, e.sdst, e.ssrc}));
    endtask

    // One cycle: check outputs from the previous slots, then present new ones
    task automatic step(input logic v0, input logic [1:0] c0, input logic [RW-1:0] d0,
                        input logic [RW-1:0] a0, input logic [RW-1:0] b0,
                        input logic v1, input logic [1:0] c1, input logic [RW-1:0] d1,
                        input logic [RW-1:0] a1, input logic [RW-1:0] b1);
        exp_t e;
        string t;
        @(negedge clk);
        compare_pending();
        s0_valid = v0; s0_class = c0; s0_dst = d0; s0_src = {b0, a0};
        s1_valid = v1; s1_class = c1; s1_dst = d1; s1_src = {b1, a1};
        predict(e, t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    initial begin
        s0_valid = 1'b1; s0_class = 2'b00; s0_dst = 5'd3; s0_src = '1;
        s1_valid = 1'b1; s1_class = 2'b00; s1_dst = 5'd4; s1_src = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1", 64'({pri_issue, sec_issue, hold_young, pri_dst, pri_src, sec_dst, sec_src}), 64'd0);
        s0_valid = 1'b0; s1_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1: first cycle after reset, slot 0 was empty
        check("R1", 64'({pri_issue, sec_issue, hold_young}), 64'd0);

        // Directed corner cases
        step(1, 0, 5, 1, 2,  1, 0, 6, 7, 8);    // R4 clean pair
        step(0, 0, 5, 1, 2,  1, 0, 6, 7, 8);    // R2 slot 0 empty
        step(1, 1, 9, 1, 2,  0, 0, 6, 7, 8);    // R3 slot 0 alone
        step(1, 0, 5, 1, 2,  1, 0, 6, 5, 8);    // R5 first source hit
        step(1, 0, 5, 1, 2,  1, 0, 6, 7, 5);    // R5 second source hit
        step(1, 0, 5, 1, 2,  1, 0, 5, 7, 8);    // R6 same destination
        step(1, 0, 0, 1, 2,  1, 0, 0, 0, 0);    // R7 register 0 everywhere
        step(1, 0, 5, 1, 2,  1, 1, 6, 7, 8);    // R8 young needs primary
        step(1, 2, 5, 1, 2,  1, 0, 6, 7, 8);    // R9 older claims both
        step(1, 3, 5, 1, 2,  1, 0, 6, 7, 8);    // R9 older reserved
        step(1, 0, 5, 1, 2,  1, 2, 6, 7, 8);    // R9 young claims both
        step(1, 1, 5, 1, 2,  1, 0, 6, 7, 8);    // R4 older primary-only pairs
        step(1, 0, 5, 1, 2,  1, 0, 6, 7, 8);    // R10 back-to-back pairs
        step(0, 0, 0, 0, 0,  0, 0, 0, 0, 0);    // R2 both empty

        // Dense random patterns on a small register range
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) != 0, 2'($urandom % 4), 5'($urandom % 4),
                 5'($urandom % 4), 5'($urandom % 4),
                 ($urandom % 4) != 0, 2'(($urandom % 3 == 0) ? $urandom % 4 : 0),
                 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4));
        end
        @(negedge clk);
        compare_pending();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule